// File: doc/BRIEF.md
# Shadow Register Synchronizer with Stale Tracking

This block is the register front end of an always-on timekeeping domain. A fast bus writes shadow copies of eight always-on words: six persistent words, an alarm word and a seconds word. A write does not reach the always-on side at once. Each write marks its register as stale. A serial copy engine then moves one shadow word at a time into the slow domain. The slow domain is modelled as a tick enable on the fast clock. Each copy takes a fixed number of slow ticks.

Software learns that a value has landed by polling a status word. That word shows one stale bit per register and carries a constant presence flag. Every register can be written in three ways. A normal write replaces the whole word. A set alias ORs the data into the word, and a clear alias clears the bits that are 1 in the data. With the aliases, single bits can change without a read-modify-write. There are also two bus-only words, control and watchdog. They take the same three write forms but are not copied.

Top module: `shreg_sync`

## Requirements
- R1: After a synchronous reset, every shadow, bus-only and slow-domain word is zero, no register is stale, and the status word (address 0x10) reads 0x8000_0000.
- R2: Any accepted write to a copied register sets that register's stale bit, which reads as 1 from the next cycle on. Status bits 16 to 21 are persistent words 0 to 5, bit 22 is alarm, bit 23 is seconds, bit 31 always reads 1, and all other status bits read 0.
- R3: Address bits 7:4 select the register: 0x3 seconds, 0x4 alarm, 0x6 to 0xB persistent words 0 to 5. Address bits 3:2 select the write form: 0 replaces, 1 ORs, 2 clears the bits set in the data, and 3 is ignored entirely, with no data change and no stale bit. A read returns the current shadow value, whether its copy is pending or not, and reads ignore bits 3:0.
- R4: Address region 0x0 (control) and region 0x5 (watchdog) are bus-only words. They take the same three write forms and never raise a stale bit.
- R5: Writes to the status region (0x1) and to unmapped regions (0x2, 0xC to 0xF) change nothing. Reads of unmapped regions return 0.
- R6: When no copy is running and some register is stale, the engine starts copying the lowest-numbered stale register on the next clock edge. A copy that is running is never pre-empted by a lower-numbered register.
- R7: A copy completes on the COPY_TICKS-th slow tick seen after its start cycle. On that edge the slow-domain word takes the shadow value and the stale bit clears. The engine then idles for one cycle before it picks the next register.
- R8: A write to the register being copied restarts the tick count. Its stale bit stays set, and the word that finally lands is the newest shadow value.
- R9: Slow-domain words change only on a clock edge where the tick input is high. Without ticks, stale bits stay set indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable marking a slow-domain tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address: region in bits 7:4, write form in bits 3:2 |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_addr | input | 8 | Read address, region in bits 7:4 |
| rd_data | output | DATA_W | Combinational read data |
| aon_regs | output | 8*DATA_W | Slow-domain copies, word i at bits i*DATA_W upward |

## Verification
The hardest situation to reach is a write landing on exactly the register in flight on the very edge its last tick arrives. Restart and commit then meet in one cycle. Lower-numbered registers must also queue up behind a copy they cannot pre-empt. Directed sequences start an alarm copy and then write persistent words while it runs, and they rewrite seconds in the middle of its copy. A long random phase follows that mixes all write forms, unmapped addresses and a dense tick pattern. Over many thousands of cycles it hits the collision edges by chance. A behavioural model with its own integer bookkeeping predicts every read and every slow-domain word, and the bench compares against it on every clock.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int NSYNC     = 8;
    localparam int SIDX_W    = 3;
    localparam int NLOCAL    = 2;
    localparam int ADDR_W    = 8;
    localparam int STALE_LSB = 16;

    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_OR      = 2'd1,
        OP_ANDN    = 2'd2,
        OP_NOP     = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_SYNC,
        RG_LOCAL,
        RG_STATUS
    } region_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_COPY
    } eng_state_e;

    typedef struct packed {
        region_e           region;
        logic [SIDX_W-1:0] sidx;
        logic              lidx;
        wr_op_e            op;
    } dec_t;

    // Region in bits 7:4, write form in bits 3:2; the copy order is
    // persistent 0..5, alarm, seconds (index 0..7).
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.region = RG_NONE;
        d.sidx   = '0;
        d.lidx   = 1'b0;
        d.op     = wr_op_e'(a[3:2]);
        case (a[7:4])
            4'h0: begin d.region = RG_LOCAL; d.lidx = 1'b0; end
            4'h1: d.region = RG_STATUS;
            4'h3: begin d.region = RG_SYNC; d.sidx = 3'd7; end
            4'h4: begin d.region = RG_SYNC; d.sidx = 3'd6; end
            4'h5: begin d.region = RG_LOCAL; d.lidx = 1'b1; end
            4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB: begin
                d.region = RG_SYNC;
                d.sidx   = SIDX_W'(a[7:4] - 4'h6);
            end
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic [NSYNC-1:0] lowest_one(input logic [NSYNC-1:0] v);
        return v & ((~v) + NSYNC'(1));
    endfunction

    function automatic logic [SIDX_W-1:0] onehot_to_idx(input logic [NSYNC-1:0] v);
        logic [SIDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NSYNC; i++)
            if (v[i]) idx = SIDX_W'(i);
        return idx;
    endfunction

endpackage

// File: rtl/shreg_bus_regs.sv
module shreg_bus_regs
    import shreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [NSYNC-1:0]        stale,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NSYNC*DATA_W-1:0] shadow_flat,
    output logic [NSYNC-1:0]        hit
);

    dec_t wdec;
    dec_t rdec;
    logic wr_live;

    assign wdec    = decode(wr_addr);
    assign rdec    = decode(rd_addr);
    assign wr_live = wr_en && (wdec.op != OP_NOP);

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] d,
                                                input wr_op_e op);
        case (op)
            OP_REPLACE: return d;
            OP_OR:      return old | d;
            OP_ANDN:    return old & ~d;
            default:    return old;
        endcase
    endfunction

    logic [DATA_W-1:0] shadow_q [NSYNC];
    logic [DATA_W-1:0] local_q  [NLOCAL];

    always_comb begin
        hit = '0;
        if (wr_live && wdec.region == RG_SYNC)
            hit[wdec.sidx] = 1'b1;
    end

    for (genvar gs = 0; gs < NSYNC; gs++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[gs] <= '0;
            else if (hit[gs])
                shadow_q[gs] <= merge(shadow_q[gs], wr_data, wdec.op);
        end
        assign shadow_flat[gs*DATA_W +: DATA_W] = shadow_q[gs];
    end

    for (genvar gl = 0; gl < NLOCAL; gl++) begin : g_local
        logic lhit;
        assign lhit = wr_live && wdec.region == RG_LOCAL && wdec.lidx == 1'(gl);
        always_ff @(posedge clk) begin
            if (rst)
                local_q[gl] <= '0;
            else if (lhit)
                local_q[gl] <= merge(local_q[gl], wr_data, wdec.op);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rdec.region)
            RG_SYNC:   rd_data = shadow_q[rdec.sidx];
            RG_LOCAL:  rd_data = local_q[rdec.lidx];
            RG_STATUS: begin
                rd_data[DATA_W-1]             = 1'b1;
                rd_data[STALE_LSB +: NSYNC]   = stale;
            end
            default:   rd_data = '0;
        endcase
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> $stable(shadow_flat)); // R3

endmodule

// File: rtl/shreg_copy_engine.sv
module shreg_copy_engine
    import shreg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int COPY_TICKS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    slow_tick,
    input  logic [NSYNC-1:0]        hit,
    input  logic [NSYNC*DATA_W-1:0] shadow_flat,
    output logic [NSYNC-1:0]        stale,
    output logic [NSYNC*DATA_W-1:0] aon_flat
);

    localparam int             CNT_W    = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COPY_TICKS - 1);

    eng_state_e        st_q;
    logic [SIDX_W-1:0] cur_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NSYNC-1:0]  stale_q;
    logic              cur_hit;
    logic              commit;
    logic [NSYNC-1:0]  retire;

    assign cur_hit = hit[cur_q];
    assign commit  = (st_q == ENG_COPY) && !cur_hit && slow_tick && (cnt_q == CNT_LAST);
    assign retire  = commit ? (NSYNC'(1) << cur_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ENG_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            stale_q <= '0;
        end else begin
            stale_q <= (stale_q & ~retire) | hit;
            case (st_q)
                ENG_IDLE: begin
                    if (|stale_q) begin
                        st_q  <= ENG_COPY;
                        cur_q <= onehot_to_idx(lowest_one(stale_q));
                        cnt_q <= '0;
                    end
                end
                ENG_COPY: begin
                    if (cur_hit)
                        cnt_q <= '0;
                    else if (slow_tick) begin
                        if (cnt_q == CNT_LAST)
                            st_q <= ENG_IDLE;
                        else
                            cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    for (genvar ga = 0; ga < NSYNC; ga++) begin : g_aon
        logic [DATA_W-1:0] aon_q;
        always_ff @(posedge clk) begin
            if (rst)
                aon_q <= '0;
            else if (commit && cur_q == SIDX_W'(ga))
                aon_q <= shadow_flat[ga*DATA_W +: DATA_W];
        end
        assign aon_flat[ga*DATA_W +: DATA_W] = aon_q;
    end

    assign stale = stale_q;

    AST_WRITE_MARKS_STALE: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((stale_q & $past(hit)) == $past(hit))); // R2

    AST_FIRST_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENG_COPY && $past(st_q) == ENG_IDLE)
            |-> ((NSYNC'(1) << cur_q) == lowest_one($past(stale_q)))); // R6

    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones($past(stale_q) & ~stale_q) <= 1)); // R7

    AST_TARGET_PENDING: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENG_COPY) |-> stale_q[cur_q]); // R8

    AST_AON_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !slow_tick |=> $stable(aon_flat)); // R9

endmodule

// File: rtl/shreg_sync.sv
module shreg_sync
    import shreg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int COPY_TICKS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    slow_tick,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NSYNC*DATA_W-1:0] aon_regs
);

    logic [NSYNC*DATA_W-1:0] shadow_flat;
    logic [NSYNC-1:0]        hit;
    logic [NSYNC-1:0]        stale;

    shreg_bus_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .stale       (stale),
        .rd_data     (rd_data),
        .shadow_flat (shadow_flat),
        .hit         (hit)
    );

    shreg_copy_engine #(.DATA_W(DATA_W), .COPY_TICKS(COPY_TICKS)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .slow_tick   (slow_tick),
        .hit         (hit),
        .shadow_flat (shadow_flat),
        .stale       (stale),
        .aon_flat    (aon_regs)
    );

endmodule

// File: tb/shreg_sync_test.sv
`timescale 1ns/1ps
module shreg_sync_test;

    localparam int DW = 32;
    localparam int CT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slow_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [255:0]  aon_regs;

    shreg_sync #(.DATA_W(DW), .COPY_TICKS(CT)) uut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .aon_regs(aon_regs)
    );

    always #2.5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_sh  [8];
    logic [31:0] m_loc [2];
    logic [31:0] m_aon [8];
    logic [7:0]  m_stl;
    bit          m_busy;
    int          m_cur;
    int          m_cnt;

    function automatic int sync_of(logic [7:0] a);
        int r = a[7:4];
        if (r >= 6 && r <= 11) return r - 6;
        if (r == 4) return 6;
        if (r == 3) return 7;
        return -1;
    endfunction

    function automatic int local_of(logic [7:0] a);
        if (a[7:4] == 4'h0) return 0;
        if (a[7:4] == 4'h5) return 1;
        return -1;
    endfunction

    function automatic logic [31:0] apply(logic [31:0] o, logic [31:0] d, int op);
        if (op == 0) return d;
        if (op == 1) return o | d;
        if (op == 2) return o & ~d;
        return o;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        int s = sync_of(a);
        int l = local_of(a);
        if (a[7:4] == 4'h1) return {1'b1, 7'b0, m_stl, 16'b0};
        if (s >= 0) return m_sh[s];
        if (l >= 0) return m_loc[l];
        return 32'h0;
    endfunction

    function automatic logic [255:0] model_aon();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = m_aon[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_sh[i] = '0; m_aon[i] = '0; end
        m_loc[0] = '0; m_loc[1] = '0;
        m_stl = '0; m_busy = 0; m_cur = 0; m_cnt = 0;
    endtask

    task automatic model_step(bit we, logic [7:0] a, logic [31:0] d, bit tk);
        int op = a[3:2];
        int s = sync_of(a);
        int l = local_of(a);
        logic [7:0] hv = '0;
        logic [7:0] cl = '0;
        if (we && op != 3 && s >= 0) hv[s] = 1'b1;
        if (m_busy) begin
            if (hv[m_cur]) m_cnt = 0;
            else if (tk) begin
                if (m_cnt == CT - 1) begin
                    m_aon[m_cur] = m_sh[m_cur];
                    cl[m_cur] = 1'b1;
                    m_busy = 0;
                end else m_cnt++;
            end
        end else if (m_stl != 0) begin
            for (int i = 7; i >= 0; i--) if (m_stl[i]) m_cur = i;
            m_busy = 1;
            m_cnt = 0;
        end
        m_stl = (m_stl & ~cl) | hv;
        if (we && op != 3) begin
            if (s >= 0) m_sh[s] = apply(m_sh[s], d, op);
            if (l >= 0) m_loc[l] = apply(m_loc[l], d, op);
        end
    endtask

    task automatic check(bit ok, string what, logic [255:0] act, logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(bit we, logic [7:0] a, logic [31:0] d, bit tk, logic [7:0] ra);
        logic [31:0] er;
        logic [255:0] ea;
        @(negedge clk);
        er = model_read(rd_addr);
        ea = model_aon();
        check(rd_data === er, "read", 256'(rd_data), 256'(er));
        check(aon_regs === ea, "slow", aon_regs, ea);
        wr_en = we; wr_addr = a; wr_data = d; slow_tick = tk; rd_addr = ra;
        model_step(we, a, d, tk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    logic [7:0] bases [13] = '{8'h00, 8'h10, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70,
                               8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hF0};

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        step(0, 8'h00, 0, 0, 8'h10);
        step(0, 8'h00, 0, 0, 8'h60);
        step(0, 8'h00, 0, 0, 8'h30);
        step(0, 8'h00, 0, 0, 8'h10);

        cur_req = "R2";
        step(1, 8'h30, 32'h0000_1234, 0, 8'h10);
        step(0, 8'h00, 0, 0, 8'h10);

        cur_req = "R9";
        repeat (6) step(0, 8'h00, 0, 0, 8'h10);

        cur_req = "R7";
        repeat (8) step(0, 8'h00, 0, 1, 8'h10);
        step(0, 8'h00, 0, 0, 8'h30);

        cur_req = "R3";
        step(1, 8'h60, 32'hF0F0_0000, 0, 8'h60);
        step(1, 8'h64, 32'h0000_000F, 0, 8'h60);
        step(1, 8'h68, 32'hF000_0000, 0, 8'h60);
        step(1, 8'h6C, 32'hFFFF_FFFF, 0, 8'h64);
        step(1, 8'h9C, 32'h1111_1111, 0, 8'h10);
        repeat (14) step(0, 8'h00, 0, 1, 8'h10);

        cur_req = "R4";
        step(1, 8'h00, 32'h0000_0011, 0, 8'h00);
        step(1, 8'h04, 32'h0000_0004, 0, 8'h00);
        step(1, 8'h08, 32'h0000_0001, 0, 8'h10);
        step(1, 8'h50, 32'h0000_ABCD, 0, 8'h50);
        step(1, 8'h58, 32'h0000_000D, 0, 8'h58);
        step(0, 8'h00, 0, 0, 8'h10);

        cur_req = "R5";
        step(1, 8'h10, 32'hFFFF_FFFF, 0, 8'h10);
        step(1, 8'hF0, 32'hFFFF_FFFF, 0, 8'hF0);
        step(1, 8'h20, 32'hFFFF_FFFF, 0, 8'h20);
        step(1, 8'hC4, 32'hFFFF_FFFF, 0, 8'h10);
        step(0, 8'h00, 0, 0, 8'hC0);

        cur_req = "R6";
        step(1, 8'h40, 32'hAAAA_0001, 0, 8'h10);
        step(1, 8'hA0, 32'h4444_0004, 1, 8'h10);
        step(1, 8'h70, 32'h1111_0001, 1, 8'h10);
        repeat (30) step(0, 8'h00, 0, 1, 8'h10);

        cur_req = "R8";
        step(1, 8'h30, 32'h0000_0001, 0, 8'h10);
        step(0, 8'h00, 0, 1, 8'h10);
        step(0, 8'h00, 0, 1, 8'h10);
        step(1, 8'h30, 32'h0000_0002, 1, 8'h10);
        repeat (3) step(0, 8'h00, 0, 1, 8'h10);
        step(1, 8'h34, 32'h0000_0100, 1, 8'h10);
        repeat (10) step(0, 8'h00, 0, 1, 8'h30);

        cur_req = "R6";
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic [7:0] ra;
            a  = bases[$urandom_range(0, 12)] | (8'($urandom_range(0, 3)) << 2);
            ra = bases[$urandom_range(0, 12)];
            step($urandom_range(0, 2) == 0, a, $urandom, $urandom_range(0, 1) == 0, ra);
        end
        cur_req = "R7";
        repeat (60) step(0, 8'h00, 0, 1, 8'h10);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

endmodule